// File: doc/BRIEF.md
# Three-Pixel Stego Bit Extractor

The block recovers a hidden message from a stego image that arrives as a stream of 8-bit grey pixels. It groups the pixels of a frame into consecutive units of three, (y0, y1, y2). Each unit gives three message bits. Each bit is the least significant bit of one pixel added to its next neighbour halved, and the neighbours wrap around inside the unit. The plain LSB of a pixel alone does not give the message bit.

Pixels enter on a valid/ready stream. Message bits leave on a valid/ready stream, either as one 3-bit word per unit or, when the `SERIAL` parameter is set, as three single-bit beats per unit. A full output stage stalls the pixel input without losing data. A frame holds `IMG_W*IMG_H` pixels, 128x128 by default, so a frame carries 5461 units. Pixels left over at the end of a frame, fewer than three, are taken in and dropped. A one-cycle pulse marks the hand-off of the last complete unit of each frame.

Top module: `stego_extract3`

## Requirements
- R1: While reset is low and in the first cycle after it, `outValid` and `frameDone` are 0 and `pixReady` is 1.
- R2: The first pixel accepted after reset, and the first pixel accepted after a frame ends, is y0 of a new unit. The next two accepted pixels are y1 and y2.
- R3: The three message bits of a unit are m0 = LSB(y0 + (y1>>1)), m1 = LSB(y1 + (y2>>1)) and m2 = LSB(y2 + (y0>>1)). The halving is an unsigned right shift by one.
- R4: In word mode (`SERIAL`=0), `outData` carries m0 on bit 0, m1 on bit 1 and m2 on bit 2. `outValid` rises in the cycle after y2 is accepted, and there is exactly one word per unit.
- R5: In serial mode (`SERIAL`=1), each unit gives three beats on the 1-bit `outData`, in the order m0, m1, m2.
- R6: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold their values. While a unit is waiting to be handed off, the y2 pixel of the next unit is refused (`pixReady`=0). No bit is lost or repeated.
- R7: A frame is `IMG_W*IMG_H` pixels. The trailing (count mod 3) pixels are accepted, produce no output and leave the unit grouping of the next frame unaffected.
- R8: `frameDone` is a one-cycle pulse. It comes in the cycle after the hand-off of the final item of the last complete unit of a frame, and at no other time.
- R9: Each frame gives exactly floor(`IMG_W*IMG_H`/3) units of output, which is 5461 for a 128x128 frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel on `pixData` is offered |
| pixReady | output | 1 | Block can take the offered pixel |
| pixData | input | PIX_W (8) | Grey stego pixel |
| outValid | output | 1 | Message item on `outData` is offered |
| outReady | input | 1 | Sink takes the offered item |
| outData | output | 3 (SERIAL=0) or 1 (SERIAL=1) | Message bits of a unit, or one bit of it |
| frameDone | output | 1 | Pulse after the last complete unit of a frame |

## Verification
A wrong unit phase, for example after a dropped tail pixel, shows up in the next unit as words built from the wrong pixels. It appears at the first hand-off after the slip, no later than three accepted pixels. A stale or lost pending flag shows up within one cycle, as an item that changes or vanishes while the sink stalls, or as a y2 pixel taken while a word waits. An off-by-one frame counter shifts the `frameDone` pulse, changes the unit count per frame and regroups the whole second frame, so it is exposed at the frame boundary.

// File: rtl/stego_extract3_pkg.sv
package stego_extract3_pkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic load0;    // take y0 of a unit
    logic load1;    // take y1 of a unit
    logic load2;    // y2 present: form the three message bits
    logic advance;  // an output item was handed off this cycle
  } xtr_strobe_t;

  localparam int unsigned UNIT_PIX = 3;

endpackage

// File: rtl/stego_extract3_ctrl.sv
module stego_extract3_ctrl
  import stego_extract3_pkg::*;
#(
  parameter int IMG_W  = 128,
  parameter int IMG_H  = 128,
  parameter int SERIAL = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pixValid,
  output logic        pixReady,
  input  logic        outReady,
  output logic        outValid,
  output logic        frameDone,
  output xtr_strobe_t strobe
);

  localparam int NPIX    = IMG_W * IMG_H;
  localparam int NUNITS  = NPIX / UNIT_PIX;
  localparam int USED    = NUNITS * UNIT_PIX;
  localparam int PIX_CW  = $clog2(NPIX + 1);
  localparam int UNIT_CW = $clog2(NUNITS + 1);
  localparam logic [PIX_CW-1:0]  LAST_PIX  = PIX_CW'(NPIX - 1);
  localparam logic [PIX_CW-1:0]  USED_PIX  = PIX_CW'(USED);
  localparam logic [UNIT_CW-1:0] LAST_UNIT = UNIT_CW'(NUNITS - 1);

  logic [PIX_CW-1:0]  pixIdx;
  logic [1:0]         slot;
  logic [UNIT_CW-1:0] unitIdx;
  logic               pending;
  logic               lastPend;
  logic [1:0]         beat;
  logic               doneR;

  logic inBody;
  logic accept;
  logic handoff;
  logic lastBeat;
  logic finalBeat;

  always_comb begin
    inBody    = pixIdx < USED_PIX;
    pixReady  = !(inBody && slot == 2'd2 && pending);
    accept    = pixValid && pixReady;
    handoff   = pending && outReady;
    lastBeat  = (SERIAL != 0) ? (beat == 2'd2) : 1'b1;
    finalBeat = handoff && lastBeat;

    strobe.load0   = accept && inBody && slot == 2'd0;
    strobe.load1   = accept && inBody && slot == 2'd1;
    strobe.load2   = accept && inBody && slot == 2'd2;
    strobe.advance = handoff;
  end

  assign outValid  = pending;
  assign frameDone = doneR;

  // Frame position and unit phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixIdx <= '0;
      slot   <= 2'd0;
    end else if (accept) begin
      if (pixIdx == LAST_PIX) begin
        pixIdx <= '0;
        slot   <= 2'd0;
      end else begin
        pixIdx <= pixIdx + 1'b1;
        slot   <= (slot == 2'd2) ? 2'd0 : slot + 2'd1;
      end
    end
  end

  // Unit count inside the frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitIdx <= '0;
    end else if (strobe.load2) begin
      unitIdx <= (unitIdx == LAST_UNIT) ? '0 : unitIdx + 1'b1;
    end
  end

  // Output occupancy, serial beat and end-of-frame pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      lastPend <= 1'b0;
      beat     <= 2'd0;
      doneR    <= 1'b0;
    end else begin
      if (strobe.load2) begin
        pending  <= 1'b1;
        lastPend <= (unitIdx == LAST_UNIT);
        beat     <= 2'd0;
      end else if (handoff) begin
        if (lastBeat) pending <= 1'b0;
        beat <= beat + 2'd1;
      end
      doneR <= finalBeat && lastPend;
    end
  end

  a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rstN)
    pending && !outReady |=> pending);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  a_r8_done_after_handoff: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> $past(handoff));

  a_r9_unit_bound: assert property (@(posedge clk) disable iff (!rstN)
    unitIdx <= LAST_UNIT);

  a_r5_beat_bound: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> beat <= 2'd2);

  a_r7_tail_no_load: assert property (@(posedge clk) disable iff (!rstN)
    !inBody |-> !(strobe.load0 || strobe.load1 || strobe.load2));

endmodule

// File: rtl/stego_extract3_dp.sv
module stego_extract3_dp
  import stego_extract3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int SERIAL = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [PIX_W-1:0]                pixData,
  input  xtr_strobe_t                     strobe,
  output logic [(SERIAL != 0 ? 1 : 3)-1:0] outData
);

  // Only the two low bits of a pixel reach a message bit:
  // LSB(a + (b>>1)) = a[0] ^ b[1].
  localparam int KEEP_W = 2;

  logic [KEEP_W-1:0] y0Lo;
  logic [KEEP_W-1:0] y1Lo;
  logic [KEEP_W-1:0] unitLo [UNIT_PIX];
  logic [2:0]        newBits;
  logic [2:0]        bitsReg;
  logic              unusedPixHigh;

  assign unusedPixHigh = ^pixData[PIX_W-1:KEEP_W];

  always_comb begin
    unitLo[0] = y0Lo;
    unitLo[1] = y1Lo;
    unitLo[2] = pixData[KEEP_W-1:0];
  end

  for (genvar g = 0; g < UNIT_PIX; g++) begin : g_msg
    assign newBits[g] = unitLo[g][0] ^ unitLo[(g + 1) % UNIT_PIX][1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      y0Lo    <= '0;
      y1Lo    <= '0;
      bitsReg <= '0;
    end else begin
      if (strobe.load0) y0Lo <= pixData[KEEP_W-1:0];
      if (strobe.load1) y1Lo <= pixData[KEEP_W-1:0];
      if (strobe.load2) begin
        bitsReg <= newBits;
      end else if (strobe.advance && SERIAL != 0) begin
        bitsReg <= bitsReg >> 1;
      end
    end
  end

  if (SERIAL != 0) begin : g_serial
    assign outData = bitsReg[0];
  end else begin : g_word
    assign outData = bitsReg;
  end

  a_r2_one_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load0, strobe.load1, strobe.load2}));

  a_r2_load_order: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load0 |=> !strobe.load2);

endmodule

// File: rtl/stego_extract3.sv
module stego_extract3
  import stego_extract3_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int IMG_W  = 128,
  parameter int IMG_H  = 128,
  parameter int SERIAL = 0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            pixValid,
  output logic                            pixReady,
  input  logic [PIX_W-1:0]                pixData,
  output logic                            outValid,
  input  logic                            outReady,
  output logic [(SERIAL != 0 ? 1 : 3)-1:0] outData,
  output logic                            frameDone
);

  xtr_strobe_t strobe;

  stego_extract3_ctrl #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .SERIAL(SERIAL)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pixValid (pixValid),
    .pixReady (pixReady),
    .outReady (outReady),
    .outValid (outValid),
    .frameDone(frameDone),
    .strobe   (strobe)
  );

  stego_extract3_dp #(
    .PIX_W (PIX_W),
    .SERIAL(SERIAL)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pixData(pixData),
    .strobe (strobe),
    .outData(outData)
  );

  a_r6_hold_out: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

endmodule

// File: tb/stego_extract3_test.sv
`timescale 1ns/1ps

module stego_extract3_sb #(
  parameter int SERIAL = 0,
  parameter int NPIX   = 16384,
  parameter int OUT_W  = 3
) (
  input logic             clk,
  input logic             pixValid,
  input logic             pixReady,
  input logic [7:0]       pixData,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData,
  input logic             frameDone
);
  localparam int USED      = (NPIX / 3) * 3;
  localparam int PER_FRAME = (NPIX / 3) * ((SERIAL != 0) ? 3 : 1);

  int checks = 0;
  int errs = 0;
  int pixPos = 0;
  int delivered = 0;
  int totalItems = 0;
  int donePulses = 0;
  bit doneDue = 0;
  bit holdOn = 0;
  logic [OUT_W-1:0] holdVal;
  logic [7:0] u0, u1;
  logic [2:0] q[$];

  function automatic logic msgBit(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = int'(a) + (int'(b) / 2);
    return logic'(s % 2);
  endfunction

  initial begin
    logic [2:0] exp;
    logic m0, m1, m2;
    forever begin
      @(negedge clk);
      if (doneDue) begin
        checks++;
        if (frameDone !== 1'b1) begin
          errs++;
          $display("FAIL R8 frameDone actual=%0b expected=1", frameDone);
        end
      end else if (frameDone === 1'b1) begin
        checks++; errs++;
        $display("FAIL R8 unexpected frameDone actual=1 expected=0");
      end
      if (frameDone === 1'b1) donePulses++;
      doneDue = 0;

      if (holdOn) begin
        checks++;
        if (!(outValid === 1'b1 && outData === holdVal)) begin
          errs++;
          $display("FAIL R6 stalled item actual=%0d/%0d expected=1/%0d", outValid, outData, holdVal);
        end
      end
      holdOn  = (outValid === 1'b1 && outReady === 1'b0);
      holdVal = outData;

      if (outValid === 1'b1 && outReady === 1'b1) begin
        checks++;
        if (q.size() == 0) begin
          errs++;
          $display("FAIL R9 extra item actual=%0d expected=none", outData);
        end else begin
          exp = q.pop_front();
          if (outData !== exp[OUT_W-1:0]) begin
            errs++;
            $display("FAIL %s message item actual=%0d expected=%0d",
                     (SERIAL != 0) ? "R5" : "R4", outData, exp[OUT_W-1:0]);
          end
        end
        totalItems++;
        delivered++;
        if (delivered == PER_FRAME) begin
          doneDue = 1;
          delivered = 0;
        end
      end

      if (pixValid === 1'b1 && pixReady === 1'b1) begin
        if (pixPos < USED) begin
          case (pixPos % 3)
            0: u0 = pixData;
            1: u1 = pixData;
            default: begin
              m0 = msgBit(u0, u1);
              m1 = msgBit(u1, pixData);
              m2 = msgBit(pixData, u0);
              if (SERIAL != 0) begin
                q.push_back({2'b00, m0});
                q.push_back({2'b00, m1});
                q.push_back({2'b00, m2});
              end else begin
                q.push_back({m2, m1, m0});
              end
            end
          endcase
        end
        pixPos = (pixPos == NPIX - 1) ? 0 : pixPos + 1;
      end
    end
  end
endmodule

module stego_extract3_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic pvG = 0, prG, ovG, orG = 1, fdG;
  logic [7:0] pdG = '0;
  logic [2:0] odG;
  logic pvS = 0, prS, ovS, orS = 1, fdS;
  logic [7:0] pdS = '0;
  logic [0:0] odS;

  int readyModeG = 0;
  int readyModeS = 0;
  int checks = 0;
  int errs = 0;
  logic [31:0] seed = 32'h1234_5678;

  localparam logic [26:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 3'b000},
    {8'hFF, 8'hFF, 8'hFF, 3'b000},
    {8'h01, 8'h00, 8'h00, 3'b001},
    {8'h00, 8'h00, 8'h02, 3'b010},
    {8'h03, 8'h00, 8'h00, 3'b101},
    {8'h00, 8'h03, 8'h00, 3'b011},
    {8'h35, 8'h6E, 8'hC7, 3'b110},
    {8'h01, 8'h01, 8'h01, 3'b111}
  };

  stego_extract3 uut (
    .clk(clk), .rstN(rstN), .pixValid(pvG), .pixReady(prG), .pixData(pdG),
    .outValid(ovG), .outReady(orG), .outData(odG), .frameDone(fdG)
  );

  stego_extract3 #(.IMG_W(4), .IMG_H(4), .SERIAL(1)) uutSer (
    .clk(clk), .rstN(rstN), .pixValid(pvS), .pixReady(prS), .pixData(pdS),
    .outValid(ovS), .outReady(orS), .outData(odS), .frameDone(fdS)
  );

  stego_extract3_sb #(.SERIAL(0), .NPIX(16384), .OUT_W(3)) sbG (
    .clk(clk), .pixValid(pvG), .pixReady(prG), .pixData(pdG),
    .outValid(ovG), .outReady(orG), .outData(odG), .frameDone(fdG)
  );

  stego_extract3_sb #(.SERIAL(1), .NPIX(16), .OUT_W(1)) sbS (
    .clk(clk), .pixValid(pvS), .pixReady(prS), .pixData(pdS),
    .outValid(ovS), .outReady(orS), .outData(odS), .frameDone(fdS)
  );

  // Output back-pressure: 0 always ready, 1 pseudo-random, 2 held off.
  initial begin
    logic [15:0] lf = 16'hACE1;
    forever begin
      @(posedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      orG = (readyModeG == 0) ? 1'b1 : (readyModeG == 1) ? lf[3] : 1'b0;
      orS = (readyModeS == 0) ? 1'b1 : (readyModeS == 1) ? lf[9] : 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nextPix();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  // Both send tasks start just after a rising edge and return just after
  // the edge at which the pixel was accepted.
  task automatic sendG(input logic [7:0] v);
    pvG = 1'b1; pdG = v;
    @(negedge clk);
    while (!prG) @(negedge clk);
    @(posedge clk); #1;
    pvG = 1'b0;
  endtask

  task automatic sendS(input logic [7:0] v);
    pvS = 1'b1; pdS = v;
    @(negedge clk);
    while (!prS) @(negedge clk);
    @(posedge clk); #1;
    pvS = 1'b0;
  endtask

  task automatic summary();
    int e, c;
    e = errs + sbG.errs + sbS.errs;
    c = checks + sbG.checks + sbS.checks;
    $display("Result: errors=%0d of %0d checks", e, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired actual=200000 expected=fewer cycles");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ovG == 0 && fdG == 0 && prG == 1, "R1 reset word instance", {ovG, fdG, prG}, 1);
    chk(ovS == 0 && fdS == 0 && prS == 1, "R1 reset serial instance", {ovS, fdS, prS}, 1);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(ovG == 0 && fdG == 0 && prG == 1, "R1 after reset", {ovG, fdG, prG}, 1);
    @(posedge clk); #1;

    // Vector table: word mode, sink always ready.
    for (int i = 0; i < 8; i++) begin
      sendG(VEC[i][26:19]);
      sendG(VEC[i][18:11]);
      @(negedge clk);
      chk(ovG == 0, "R4 no word before y2", ovG, 0);
      @(posedge clk); #1;
      sendG(VEC[i][10:3]);
      @(negedge clk);
      chk(ovG == 1 && odG == VEC[i][2:0], "R3 R4 table word", odG, VEC[i][2:0]);
      @(posedge clk); #1;
    end

    // Rest of a 128x128 frame under random back-pressure (R6, R7, R9).
    readyModeG = 1;
    for (int i = 24; i < 16384; i++) sendG(nextPix());
    readyModeG = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(ovG == 0, "R7 tail pixel gives no output", ovG, 0);
    chk(sbG.totalItems == 5461, "R9 units per frame", sbG.totalItems, 5461);
    chk(sbG.donePulses == 1, "R8 one pulse per frame", sbG.donePulses, 1);
    @(posedge clk); #1;

    // Next frame regroups from its first pixel (R2, R7).
    for (int i = 6; i < 8; i++) begin
      sendG(VEC[i][26:19]);
      sendG(VEC[i][18:11]);
      sendG(VEC[i][10:3]);
      @(negedge clk);
      chk(ovG == 1 && odG == VEC[i][2:0], "R2 second frame grouping", odG, VEC[i][2:0]);
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sbG.totalItems == 5463, "R9 second frame count", sbG.totalItems, 5463);
    @(posedge clk); #1;

    // Serial mode: stall the sink and hold the next y2 off (R5, R6).
    readyModeS = 2;
    @(posedge clk); #1;
    sendS(8'h35); sendS(8'h6E); sendS(8'hC7);
    sendS(8'h01); sendS(8'h01);
    pvS = 1'b1; pdS = 8'h01;
    @(negedge clk);
    chk(prS == 0, "R6 y2 refused while unit pending", prS, 0);
    chk(ovS == 1 && odS == 1'b0, "R5 first beat is m0", odS, 0);
    repeat (3) @(negedge clk);
    chk(prS == 0 && ovS == 1, "R6 stall persists", {prS, ovS}, 1);
    @(posedge clk); #1;
    readyModeS = 0;
    sendS(8'h01);
    readyModeS = 1;
    for (int i = 6; i < 32; i++) sendS(nextPix());
    readyModeS = 0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(sbS.totalItems == 30, "R9 R5 serial beats over two frames", sbS.totalItems, 30);
    chk(sbS.donePulses == 2, "R8 serial frame pulses", sbS.donePulses, 2);
    chk(ovS == 0 && sbS.q.size() == 0, "R7 serial tail dropped", sbS.q.size(), 0);

    summary();
    $finish;
  end
endmodule